// File: doc/BRIEF.md
# Product-Term Clocked Output Cell

This block is one output cell of a programmable sum-of-products fabric that is meant for asynchronous systems. No global clock reaches it. The cell's storage element is clocked by a product term, and it is set and cleared by two more product terms. These terms come from the fabric's AND array and are built from external inputs and fed-back state. The data input of the storage element is the OR of a parameterised number of product terms.

Around the storage element there are three selectors. One picks the pad's output enable, either from a dedicated enable pin or from an enable product term. A second picks what returns to the array, either the stored bit or the level on the pad. A third picks what reaches the shared input path, either this cell's own pad-side input register or the input register of the adjacent cell. The pad-side input register samples the pad on its own product-term clock and has its own set and clear terms. Its value is also brought out so that the neighbouring cell can share it.

Top module: `async_reg_macrocell`

## Requirements
- R1: On each rising edge of `clk_pt`, with `set_pt` and `rst_pt` both low, the output register stores the OR of all `NUM_PT` bits of `sum_pt`.
- R2: A high level on `set_pt` forces the output register to 1 at once, with no edge on `clk_pt`.
- R3: A high level on `rst_pt` forces the output register to 0 at once. When `set_pt` and `rst_pt` are high together, the register holds 0.
- R4: While `set_pt` or `rst_pt` is high, rising edges of `clk_pt` leave the output register unchanged.
- R5: `pin_oe` equals `oe_pin` when `oe_src` is 0 and equals `oe_pt` when `oe_src` is 1.
- R6: `fb_out` equals the output register when `fb_src` is 0 and equals `pin_in` when `fb_src` is 1.
- R7: The input register stores `pin_in` on each rising edge of `in_clk_pt`. `in_set_pt` forces it to 1 and `in_rst_pt` forces it to 0, both at once. Clear wins when both are high, and clock edges are ignored while either is high. Its value appears on `inreg_q`.
- R8: `share_out` equals `inreg_q` when `share_src` is 0 and equals `nbr_inreg` when `share_src` is 1.
- R9: Before any edge on any control term, both registers read 0.
- R10: `pin_out` always shows the output register's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sum_pt | input | NUM_PT | Product terms ORed into the register's data input |
| clk_pt | input | 1 | Register clock product term, rising edge active |
| set_pt | input | 1 | Asynchronous set product term for the output register |
| rst_pt | input | 1 | Asynchronous clear product term for the output register, dominant |
| oe_pt | input | 1 | Output-enable product term |
| oe_pin | input | 1 | Dedicated output-enable pin |
| oe_src | input | 1 | Enable source: 0 pin, 1 product term |
| fb_src | input | 1 | Feedback source: 0 register, 1 pad |
| pin_in | input | 1 | Level seen on the pad |
| in_clk_pt | input | 1 | Input register clock product term |
| in_set_pt | input | 1 | Input register asynchronous set |
| in_rst_pt | input | 1 | Input register asynchronous clear, dominant |
| nbr_inreg | input | 1 | Input register value of the adjacent cell |
| share_src | input | 1 | Shared path source: 0 own input register, 1 neighbour |
| pin_out | output | 1 | Stored value driven toward the pad |
| pin_oe | output | 1 | Selected pad output enable |
| fb_out | output | 1 | Feedback into the array |
| inreg_q | output | 1 | Input register value, offered to the adjacent cell |
| share_out | output | 1 | Shared input path into the array |

## Verification
The bench builds the cell with `NUM_PT` left at 8. With eight terms, sparse random term vectors reach both outcomes of the OR: an all-zero vector and a vector with exactly one term set. A wider sum would make an all-zero vector rare under random draws. Directed cases hold clear and set across clock pulses, assert both together, and walk a single term through every position, so each of the eight OR inputs is shown to reach the register.

// File: rtl/amc_pkg.sv
package amc_pkg;
   typedef enum logic {OE_FROM_PIN = 1'b0, OE_FROM_PT = 1'b1} oe_src_e;
   typedef enum logic {FB_FROM_REG = 1'b0, FB_FROM_PAD = 1'b1} fb_src_e;
   typedef enum logic {SH_FROM_OWN = 1'b0, SH_FROM_NBR = 1'b1} sh_src_e;
endpackage

// File: rtl/amc_term_or.sv
module amc_term_or #(
   parameter int NUM_PT = 8
) (
   input  logic [NUM_PT-1:0] terms,
   output logic              sum
);
   localparam int LAST = NUM_PT - 1;

   if (NUM_PT < 1) begin : g_bad_width
      $error("amc_term_or: NUM_PT must be at least 1");
   end

   if (NUM_PT == 1) begin : g_single
      assign sum = terms[0];
   end else begin : g_chain
      logic [LAST:0] acc;
      assign acc[0] = terms[0];
      for (genvar i = 1; i <= LAST; i++) begin : g_or
         assign acc[i] = acc[i-1] | terms[i];
      end
      assign sum = acc[LAST];
   end
endmodule

// File: rtl/amc_sr_flop.sv
module amc_sr_flop (
   input  logic clk,
   input  logic set,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic q_r = 1'b0;

   always_ff @(posedge clk or posedge set or posedge rst) begin
      if (rst)      q_r <= 1'b0;
      else if (set) q_r <= 1'b1;
      else          q_r <= d;
   end

   assign q = q_r;

   // shadow of the sampled data, used only by the capture check
   logic d_seen = 1'b0;
   always_ff @(posedge clk) d_seen <= d;

   // R1 / R7: between a clock rise and its fall the stored bit is the sampled data
   p_capture_r1_r7: assert property (@(negedge clk) disable iff (rst || set)
      1'b1 |-> (q_r == d_seen))
      else $error("capture mismatch");

   // R3: the stored bit never rises while clear is high
   always @(posedge q_r) begin
      p_rise_guard_r3: assert (!rst) else $error("rose under clear");
   end
endmodule

// File: rtl/async_reg_macrocell.sv
module async_reg_macrocell #(
   parameter int NUM_PT = 8
) (
   input  logic [NUM_PT-1:0] sum_pt,
   input  logic              clk_pt,
   input  logic              set_pt,
   input  logic              rst_pt,
   input  logic              oe_pt,
   input  logic              oe_pin,
   input  logic              oe_src,
   input  logic              fb_src,
   input  logic              pin_in,
   input  logic              in_clk_pt,
   input  logic              in_set_pt,
   input  logic              in_rst_pt,
   input  logic              nbr_inreg,
   input  logic              share_src,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              fb_out,
   output logic              inreg_q,
   output logic              share_out
);
   import amc_pkg::*;

   if (NUM_PT < 1 || NUM_PT > 64) begin : g_bad_param
      $error("async_reg_macrocell: NUM_PT out of range 1..64");
   end

   logic d_sum;
   logic out_q;
   logic in_q;

   amc_term_or #(.NUM_PT(NUM_PT)) u_or (
      .terms (sum_pt),
      .sum   (d_sum)
   );

   amc_sr_flop u_out_reg (
      .clk (clk_pt),
      .set (set_pt),
      .rst (rst_pt),
      .d   (d_sum),
      .q   (out_q)
   );

   amc_sr_flop u_in_reg (
      .clk (in_clk_pt),
      .set (in_set_pt),
      .rst (in_rst_pt),
      .d   (pin_in),
      .q   (in_q)
   );

   oe_src_e oe_sel;
   fb_src_e fb_sel;
   sh_src_e sh_sel;
   assign oe_sel = oe_src_e'(oe_src);
   assign fb_sel = fb_src_e'(fb_src);
   assign sh_sel = sh_src_e'(share_src);

   always_comb begin
      pin_oe    = (oe_sel == OE_FROM_PT)  ? oe_pt     : oe_pin;
      fb_out    = (fb_sel == FB_FROM_PAD) ? pin_in    : out_q;
      share_out = (sh_sel == SH_FROM_NBR) ? nbr_inreg : in_q;
   end

   assign pin_out = out_q;
   assign inreg_q = in_q;

   // R6: register feedback matches the value driven toward the pad
   p_fb_reg_r6: assert property (@(negedge clk_pt) disable iff (set_pt || rst_pt)
      (fb_src == 1'b0) |-> (fb_out == pin_out))
      else $error("feedback differs from pad data");

   // R8: own shared path matches the exported input register
   p_share_own_r8: assert property (@(negedge in_clk_pt) disable iff (in_set_pt || in_rst_pt)
      (share_src == 1'b0) |-> (share_out == inreg_q))
      else $error("shared path differs from input register");
endmodule

// File: tb/async_reg_macrocell_tb_top.sv
`timescale 1ns/1ps
module async_reg_macrocell_tb_top;
   localparam int N = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [N-1:0] sum_pt = '0;
   logic clk_pt = 0, set_pt = 0, rst_pt = 0, oe_pt = 0, oe_pin = 0, oe_src = 0, fb_src = 0;
   logic pin_in = 0, in_clk_pt = 0, in_set_pt = 0, in_rst_pt = 0, nbr_inreg = 0, share_src = 0;
   logic pin_out, pin_oe, fb_out, inreg_q, share_out;

   async_reg_macrocell #(.NUM_PT(N)) dut_i (
      .sum_pt(sum_pt), .clk_pt(clk_pt), .set_pt(set_pt), .rst_pt(rst_pt),
      .oe_pt(oe_pt), .oe_pin(oe_pin), .oe_src(oe_src), .fb_src(fb_src),
      .pin_in(pin_in), .in_clk_pt(in_clk_pt), .in_set_pt(in_set_pt), .in_rst_pt(in_rst_pt),
      .nbr_inreg(nbr_inreg), .share_src(share_src),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .inreg_q(inreg_q), .share_out(share_out)
   );

   int n_run = 0, n_fail = 0;
   logic exp_q = 0, exp_iq = 0;

   function automatic logic f_or(input logic [N-1:0] t);
      logic r = 1'b0;
      for (int i = 0; i < N; i++) r = r | t[i];
      return r;
   endfunction

   function automatic logic f_sr(input logic cur, input logic s, input logic r);
      if (r) return 1'b0;
      if (s) return 1'b1;
      return cur;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic out_clock(input logic [N-1:0] t, input string req);
      @(posedge clk); #1 sum_pt = t;
      @(negedge clk); clk_pt = 1'b1;
      if (!set_pt && !rst_pt) exp_q = f_or(t);
      @(posedge clk); #1 clk_pt = 1'b0;
      @(negedge clk); chk(req, pin_out, exp_q);
   endtask

   task automatic in_clock(input logic v, input string req);
      @(posedge clk); #1 pin_in = v;
      @(negedge clk); in_clk_pt = 1'b1;
      if (!in_set_pt && !in_rst_pt) exp_iq = v;
      @(posedge clk); #1 in_clk_pt = 1'b0;
      @(negedge clk); chk(req, inreg_q, exp_iq);
   endtask

   task automatic out_sr(input logic s, input logic r, input string req);
      @(posedge clk); #1 set_pt = s; rst_pt = r;
      exp_q = f_sr(exp_q, s, r);
      @(negedge clk); chk(req, pin_out, exp_q);
      @(posedge clk); #1 set_pt = 1'b0; rst_pt = 1'b0;
      @(negedge clk); chk(req, pin_out, exp_q);
   endtask

   task automatic in_sr(input logic s, input logic r, input string req);
      @(posedge clk); #1 in_set_pt = s; in_rst_pt = r;
      exp_iq = f_sr(exp_iq, s, r);
      @(negedge clk); chk(req, inreg_q, exp_iq);
      @(posedge clk); #1 in_set_pt = 1'b0; in_rst_pt = 1'b0;
      @(negedge clk); chk(req, inreg_q, exp_iq);
   endtask

   task automatic mux_checks();
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         oe_src = $urandom; oe_pt = $urandom; oe_pin = $urandom;
         fb_src = $urandom; pin_in = $urandom;
         share_src = $urandom; nbr_inreg = $urandom;
         @(negedge clk);
         chk("R5", pin_oe, oe_src ? oe_pt : oe_pin);
         chk("R6", fb_out, fb_src ? pin_in : exp_q);
         chk("R8", share_out, share_src ? nbr_inreg : exp_iq);
         chk("R10", pin_out, exp_q);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      #1;
      chk("R9", pin_out, 1'b0);
      chk("R9", inreg_q, 1'b0);
      chk("R10", fb_out, 1'b0);

      // R1: walk a single term through every position
      for (int i = 0; i < N; i++) begin
         out_clock(N'(1) << i, "R1");
         out_clock('0, "R1");
      end
      out_clock('1, "R1");

      // R2 and R3
      out_sr(1'b1, 1'b0, "R2");
      out_sr(1'b0, 1'b1, "R3");
      out_sr(1'b1, 1'b1, "R3");
      out_sr(1'b1, 1'b0, "R2");

      // R4: clock ignored while clear held, then while set held
      @(posedge clk); #1 rst_pt = 1'b1; exp_q = 1'b0;
      out_clock('1, "R4");
      @(posedge clk); #1 rst_pt = 1'b0;
      @(posedge clk); #1 set_pt = 1'b1; exp_q = 1'b1;
      out_clock('0, "R4");
      @(posedge clk); #1 set_pt = 1'b0;
      @(negedge clk); chk("R4", pin_out, 1'b1);

      // R7: input register
      in_clock(1'b1, "R7");
      in_clock(1'b0, "R7");
      in_sr(1'b1, 1'b0, "R7");
      in_sr(1'b1, 1'b1, "R7");
      @(posedge clk); #1 in_rst_pt = 1'b1;
      in_clock(1'b1, "R7");
      @(posedge clk); #1 in_rst_pt = 1'b0;

      mux_checks();

      // constrained random mix
      for (int it = 0; it < 80; it++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0, 1: out_clock(N'($urandom) & N'($urandom) & N'($urandom), "R1");
            2:    out_sr(1'($urandom), 1'($urandom), "R3");
            3:    in_clock(1'($urandom), "R7");
            4:    in_sr(1'($urandom), 1'($urandom), "R7");
            default: mux_checks();
         endcase
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule